// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus side of a small serial port. Software reaches it through a simple 32-bit memory-mapped request port. It sees three registers: a transmit byte register, a receive byte register and a status word. The serial transmitter and receiver sit outside the block. Each one connects through a valid/ready byte stream.

A received byte is taken only when the single-entry holding register is empty. The byte then stays there until software reads the receive register, and that read also empties the holding register. The receive stream's ready is driven only by a flop, so it is never a function of the bus. While the holding register is full, `rx_ready` stays low and the receiver must hold `rx_valid` and `rx_data` until the byte is taken. On the transmit side a written byte is staged in one output register. That register keeps `tx_valid` and `tx_data` steady until the transmitter raises `tx_ready`. A transfer happens on any rising edge where valid and ready are both high.

Every bus request is answered one cycle later: `bus_rvalid` for reads, plus `bus_err` for any access that was refused. A refused access changes no state.

Top module: `sio_regs`

## Requirements
- R1: Out of reset, `bus_rvalid`, `bus_err` and `tx_valid` are low and `rx_ready` is high. A status read then returns 0x2 while `tx_ready` is high, and a receive register read returns 0.
- R2: A legal read of the status word at byte address 0x08 returns bit 0 = receive-full flag and bit 1 = transmit-ready flag, with all other bits zero. The read changes no state.
- R3: A legal read of the receive register at byte address 0x04 returns the held byte zero-extended to 32 bits. The same access clears the receive-full flag.
- R4: `rx_ready` equals the inverse of the receive-full flag. A handshake on the receive stream stores `rx_data` and sets the flag. The held byte does not change while the flag stays set.
- R5: A byte offered in the same cycle as a clearing receive read is not taken in that cycle, because `rx_ready` is low. It is taken on the next cycle.
- R6: A legal write to byte address 0x00 while the transmit-ready flag is high raises `tx_valid` on the next cycle, with `tx_data` equal to write data bits 7:0. Both stay unchanged until the cycle `tx_ready` is high.
- R7: The transmit-ready flag is `tx_ready` high with no byte staged. A transmit write while the flag is low is dropped and raises `bus_err`.
- R8: Writes to the status word and to the receive register change no state and raise no error.
- R9: Reserved word offsets 3 to 5 (byte addresses 0x0C to 0x14) and any address at or beyond 0x18 raise `bus_err`, read as zero, and ignore writes.
- R10: An access with `bus_be` not equal to 4'b1111, or with address bits 1:0 nonzero, raises `bus_err` and changes no state. For example, a narrow receive read leaves the flag set.
- R11: `bus_rvalid` pulses exactly one cycle after each read request. `bus_err` pulses exactly one cycle after each refused request. `bus_rdata` is zero for refused reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; all ones for a legal access |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response pulse |
| bus_err | output | 1 | Refused-access pulse |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Holding register can take a byte |
| tx_valid | output | 1 | Staged byte for the transmitter |
| tx_data | output | 8 | Staged byte |
| tx_ready | input | 1 | Transmitter can take a byte |

## Verification
On every cycle the assertions check the following. The held byte and staged transmit byte stay stable under back-pressure. A captured byte equals the byte offered. Status reads and refused accesses leave the receive flag alone. Responses arrive only one cycle after a request. The register map values themselves can only be shown by bench scenarios. These cover the zero-extended read data, reset values, the reserved and narrow access decode, and the arrival that collides with a clearing read. Dropped transmit writes are also exercised there.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned BE_W       = BUS_W / 8;
  localparam int unsigned FLAG_RX    = 0;
  localparam int unsigned FLAG_TX    = 1;

  typedef enum logic [2:0] {
    SEL_TXD  = 3'd0,
    SEL_RXD  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_RSVD = 3'd3,
    SEL_NONE = 3'd4
  } sel_e;
endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode
  import sio_regs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned WINDOW_BYTES = 24
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output sel_e              sel,
  output logic              access_ok,
  output logic              access_bad
);
  localparam int unsigned NUM_WORDS = WINDOW_BYTES / WORD_BYTES;
  localparam int unsigned IDX_W     = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             whole;
  logic             mapped;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign whole   = &be;

  always_comb begin
    if (idx == IDX_W'(0))              sel = SEL_TXD;
    else if (idx == IDX_W'(1))         sel = SEL_RXD;
    else if (idx == IDX_W'(2))         sel = SEL_STAT;
    else if (idx < IDX_W'(NUM_WORDS))  sel = SEL_RSVD;
    else                               sel = SEL_NONE;
  end

  assign mapped     = (sel == SEL_TXD) || (sel == SEL_RXD) || (sel == SEL_STAT);
  assign access_ok  = req && aligned && whole && mapped;
  assign access_bad = req && !(aligned && whole && mapped);
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              clr,
  output logic              full,
  output logic [BYTE_W-1:0] hold
);
  logic              full_q;
  logic [BYTE_W-1:0] hold_q;
  logic              take;

  assign rx_ready = !full_q;
  assign take     = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (clr)  full_q <= 1'b0;
      if (take) begin
        full_q <= 1'b1;
        hold_q <= rx_data;
      end
    end
  end

  assign full = full_q;
  assign hold = hold_q;

  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (full_q && hold_q == $past(rx_data))) else $error("capture"); // R4
  AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr) |=> (full_q && $stable(hold_q))) else $error("hold"); // R4
  AST_RX_NO_TAKE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && full_q) |=> !full_q) else $error("clear"); // R5
endmodule

// File: rtl/sio_tx_stage.sv
module sio_tx_stage #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              flag,
  output logic              drop,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready
);
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;
  logic              accept;

  assign flag   = tx_ready && !valid_q;
  assign accept = wr_req && flag;
  assign drop   = wr_req && !flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (valid_q && tx_ready) valid_q <= 1'b0;
      if (accept) begin
        valid_q <= 1'b1;
        data_q  <= wr_byte;
      end
    end
  end

  assign tx_valid = valid_q;
  assign tx_data  = data_q;

  AST_TX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !tx_ready) |=> (valid_q && $stable(data_q))) else $error("txhold"); // R6
  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (valid_q && data_q == $past(wr_byte))) else $error("txload"); // R6
  AST_TX_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && valid_q && !tx_ready) |=> $stable(data_q)) else $error("txdrop"); // R7
endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_regs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned WINDOW_BYTES = 24,
  parameter int unsigned BYTE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready
);
  sel_e              sel;
  logic              access_ok, access_bad;
  logic              rd_ok, wr_ok;
  logic              rx_full, tx_flag, tx_drop;
  logic [BYTE_W-1:0] rx_byte;
  logic [BUS_W-1:0]  rd_mux;
  logic [BUS_W-1:0]  status_word;
  logic [BUS_W-1:0]  rdata_q;
  logic              rvalid_q, err_q;

  sio_bus_decode #(.ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES)) u_dec (
    .req(bus_req), .addr(bus_addr), .be(bus_be),
    .sel(sel), .access_ok(access_ok), .access_bad(access_bad)
  );

  assign rd_ok = access_ok && !bus_we;
  assign wr_ok = access_ok && bus_we;

  sio_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .clr(rd_ok && sel == SEL_RXD), .full(rx_full), .hold(rx_byte)
  );

  sio_tx_stage #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_ok && sel == SEL_TXD), .wr_byte(bus_wdata[BYTE_W-1:0]),
    .flag(tx_flag), .drop(tx_drop),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  always_comb begin
    status_word          = '0;
    status_word[FLAG_RX] = rx_full;
    status_word[FLAG_TX] = tx_flag;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_ok) begin
      case (sel)
        SEL_RXD:  rd_mux = BUS_W'(rx_byte);
        SEL_STAT: rd_mux = status_word;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= bus_req && !bus_we;
      err_q    <= access_bad || tx_drop;
      if (bus_req && !bus_we) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign bus_err    = err_q;

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_we)) else $error("rvalid"); // R11
  AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_req)) else $error("err"); // R11
  AST_STAT_NO_SIDE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && sel == SEL_STAT && rx_full) |=> rx_full) else $error("stat"); // R2
  AST_BAD_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (access_bad && rx_full) |=> rx_full) else $error("bad"); // R10
endmodule

// File: tb/sio_regs_tb.sv
module sio_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;

  int n_chk = 0, n_bad = 0;
  logic        m_full = 1'b0;
  logic [7:0]  m_data = '0;
  logic [31:0] r_data;
  logic        r_valid, r_err;

  always #4 clk = ~clk;

  sio_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input logic txf, input logic rxf);
    return {30'b0, txf, rxf};
  endfunction

  function automatic logic exp_bad(input logic [7:0] a, input logic [3:0] be);
    return (be != 4'hF) || (a[1:0] != 2'b00) || (a[7:2] > 6'd2);
  endfunction

  task automatic access(input logic we, input logic [7:0] a,
                        input logic [31:0] wd, input logic [3:0] be);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd; bus_be = be;
    @(posedge clk); #1;
    bus_req = 1'b0;
    r_data = bus_rdata; r_valid = bus_rvalid; r_err = bus_err;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 chk("R4 rx_ready", {31'b0, rx_ready}, {31'b0, !m_full});
    @(posedge clk); #1;
    rx_valid = 1'b0;
    if (!m_full) begin m_full = 1'b1; m_data = b; end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 rvalid", {31'b0, bus_rvalid}, 0);
    chk("R1 err", {31'b0, bus_err}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    access(0, 8'h08, 0, 4'hF);
    chk("R1 status", r_data, 32'h2);
    chk("R11 rvalid", {31'b0, r_valid}, 1);
    access(0, 8'h04, 0, 4'hF);
    chk("R1 rxd", r_data, 0);
    @(posedge clk); #1;
    chk("R11 rvalid pulse", {31'b0, bus_rvalid}, 0);

    // R3 / R4 basic receive
    push(8'hA5);
    access(0, 8'h08, 0, 4'hF);
    chk("R2 status full", r_data, exp_status(1, 1));
    access(0, 8'h08, 0, 4'hF);
    chk("R2 status no side effect", r_data, exp_status(1, 1));
    push(8'h3C);                       // refused: holder full (R4)
    access(0, 8'h04, 0, 4'hF);
    chk("R3 rxd data", r_data, 32'hA5);
    m_full = 1'b0;
    access(0, 8'h08, 0, 4'hF);
    chk("R3 flag cleared", r_data, exp_status(1, 0));

    // R10 narrow read keeps flag
    push(8'h77);
    access(0, 8'h04, 0, 4'h1);
    chk("R10 narrow err", {31'b0, r_err}, 1);
    chk("R11 narrow rdata zero", r_data, 0);
    access(0, 8'h05, 0, 4'hF);
    chk("R10 misaligned err", {31'b0, r_err}, 1);
    access(0, 8'h08, 0, 4'hF);
    chk("R10 flag kept", r_data, exp_status(1, 1));

    // R5 collision: clearing read with arrival
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h04; bus_be = 4'hF;
    rx_valid = 1'b1; rx_data = 8'hC3;
    #1 chk("R5 ready low on clear", {31'b0, rx_ready}, 0);
    @(posedge clk); #1;
    bus_req = 1'b0;
    chk("R5 old byte returned", bus_rdata, 32'h77);
    @(negedge clk);
    chk("R5 ready next cycle", {31'b0, rx_ready}, 1);
    @(posedge clk); #1;
    rx_valid = 1'b0;
    m_full = 1'b1; m_data = 8'hC3;
    access(0, 8'h04, 0, 4'hF);
    chk("R5 late byte taken", r_data, 32'hC3);
    m_full = 1'b0;

    // R8 ignored writes
    push(8'h11);
    access(1, 8'h08, 32'h0, 4'hF);
    chk("R8 stat write no err", {31'b0, r_err}, 0);
    access(1, 8'h04, 32'hFF, 4'hF);
    chk("R8 rxd write no err", {31'b0, r_err}, 0);
    access(0, 8'h08, 0, 4'hF);
    chk("R8 status unchanged", r_data, exp_status(1, 1));
    access(0, 8'h04, 0, 4'hF);
    chk("R8 rxd unchanged", r_data, 32'h11);
    m_full = 1'b0;

    // R9 reserved and out of window
    for (int k = 3; k < 8; k++) begin
      access(0, 8'(k * 4), 0, 4'hF);
      chk("R9 reserved err", {31'b0, r_err}, 1);
      chk("R9 reserved zero", r_data, 0);
    end
    access(1, 8'h0C, 32'h5A, 4'hF);
    chk("R9 write err", {31'b0, r_err}, 1);
    chk("R9 no tx", {31'b0, tx_valid}, 0);

    // R6 / R7 transmit
    access(1, 8'h00, 32'h1234_56AB, 4'hF);
    chk("R6 no err", {31'b0, r_err}, 0);
    chk("R6 tx_valid", {31'b0, tx_valid}, 1);
    chk("R6 tx_data", {24'b0, tx_data}, 32'hAB);
    tx_ready = 1'b0;
    @(posedge clk); #1;
    chk("R6 hold valid", {31'b0, tx_valid}, 1);
    chk("R6 hold data", {24'b0, tx_data}, 32'hAB);
    access(0, 8'h08, 0, 4'hF);
    chk("R7 flag low", r_data, exp_status(0, 0));
    access(1, 8'h00, 32'h99, 4'hF);
    chk("R7 dropped err", {31'b0, r_err}, 1);
    chk("R7 data kept", {24'b0, tx_data}, 32'hAB);
    tx_ready = 1'b1;
    @(posedge clk); #1;
    chk("R6 drained", {31'b0, tx_valid}, 0);
    access(1, 8'h00, 32'h42, 4'h3);
    chk("R10 narrow tx err", {31'b0, r_err}, 1);
    @(posedge clk); #1;
    chk("R10 narrow tx no send", {31'b0, tx_valid}, 0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] b, a;
      logic [3:0] be;
      op = int'($urandom % 6);
      b  = 8'($urandom);
      case (op)
        0: push(b);
        1: begin
          access(0, 8'h08, 0, 4'hF);
          chk("R2 rand status", r_data, exp_status(1, m_full));
        end
        2: begin
          access(0, 8'h04, 0, 4'hF);
          chk("R3 rand rxd", r_data, {24'b0, m_data});
          m_full = 1'b0;
        end
        3: begin
          access(1, 8'h00, {24'($urandom), b}, 4'hF);
          chk("R6 rand err", {31'b0, r_err}, 0);
          chk("R6 rand data", {24'b0, tx_data}, {24'b0, b});
          @(posedge clk); #1;
          chk("R6 rand drain", {31'b0, tx_valid}, 0);
        end
        4: begin
          a  = 8'($urandom);
          be = ($urandom % 2) ? 4'hF : 4'($urandom);
          if (!exp_bad(a, be)) be = 4'h7;
          access(0, a, 0, be);
          chk("R9 R10 rand err", {31'b0, r_err}, 1);
          chk("R11 rand rdata zero", r_data, 0);
        end
        default: begin
          access(1, ($urandom % 2) ? 8'h08 : 8'h04, 32'($urandom), 4'hF);
          chk("R8 rand err", {31'b0, r_err}, 0);
        end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule